// File: doc/BRIEF.md
# Secondary Cache Maintenance Command Queue

This block is the register front-end of a secondary cache's maintenance engine. Software uses a simple request/acknowledge register bus. It writes an operation word, and then the operands that this operation needs: a start address, a byte size, and a way mask. It then reads the entry-status register. That read closes the entry. The block checks the fields and either starts the operation or reports the entry as failed, so that software can write it again.

An accepted operation walks a modelled line space. A range operation visits every 128-byte line that the range touches. A whole-cache or way operation visits a parameterised number of sets. The block pulses a per-line strobe in place of real array and memory traffic. When the walk ends, the queue leaves its busy state and, if the operation word asked for it, raises a completion flag. Software clears that flag with a write-one.

A separate primitive register accepts a sync command. The sync first waits for any running walk to finish and then for a fixed drain interval. A read of the primitive register is not acknowledged until the drain is over.

Top module: `cmq_top`

## Requirements
- R1: After reset, the entry-status register (word 4) and the queue-status register (word 5) both read 0, and no line strobe occurs.
- R2: A write to the operation word (word 0) while the queue is idle opens an entry. The operation word fields are: bits [2:0] command, bits [18:17] scope (0 range, 1 whole cache, 2 ways), bits [22:21] target class (0 data LRU, 1 instruction LRU, 2 way-targeted), and bit 15 notify. From the moment the entry opens until its walk ends, queue-status bit 0 (busy) reads 1.
- R3: A write to the operation word while a walk runs is discarded and sets entry-status bit 0 (overflow). The running walk keeps its own command and line count.
- R4: The read of word 4 that closes an entry fails the entry in any of these cases: scope 3; target class 3; a range scope with size 0 or size above MAX_BYTES; or a way mask of 0 when the scope is 2 or the target class is 2. A failed entry returns entry-status bit 1 in that read data and sets queue-status bit 1. It produces no strobe and leaves the queue idle.
- R5: A range entry (address in word 1, size in word 2) gives ceil((addr mod 128 + size) / 128) strobes. The strobe addresses start at the address rounded down to 128 and rise by 128 on each strobe. lineCmd carries the command bits [2:0].
- R6: A whole-cache entry gives NUM_SETS strobes at addresses set*128. Address and size are ignored, so a size of 0 is accepted.
- R7: When the scope is 2 or the target class is 2, lineWays carries the way mask written to word 3. Otherwise lineWays is all ones.
- R8: After the last strobe, busy clears. Queue-status bit 2 (done) sets only if notify was set, so that the register then reads exactly 4.
- R9: A write to word 5 with bit 2 set clears done. A write with bit 2 clear leaves done unchanged.
- R10: Writing 8 to the primitive register (word 6) starts a sync. A read of word 6 is then not acknowledged until any running walk has ended and DRAIN_CYCLES further cycles have passed. Any other value written there is ignored, and the read is acknowledged at once.
- R11: Opening a new entry clears both entry-status flags and the queue-status failure bit, so that a retried entry can succeed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busReq | input | 1 | Bus request, held until busAck |
| busWr | input | 1 | 1 write, 0 read |
| busAddr | input | 3 | Register word index |
| busWdata | input | 32 | Write data |
| busAck | output | 1 | One-cycle acknowledge |
| busRdata | output | 32 | Read data, valid with busAck |
| lineStb | output | 1 | One pulse per walked line or set |
| lineAddr | output | 32 | Line address of the current strobe |
| lineCmd | output | 3 | Command of the running operation |
| lineWays | output | NUM_WAYS | Way mask of the current strobe |

## Verification
The hardest situations to reach are those that need bus traffic to land while a walk is in progress: an operation-word write that must overflow, and a sync whose read has to stall past the end of the walk. The stimulus starts a whole-cache walk of 64 sets, which gives a window much longer than a bus transfer. It then issues the colliding writes and reads inside that window. The bench records the cycle of the last strobe, so that it can compare the acknowledge cycle of the stalled read against that cycle.

// File: rtl/cmq_pkg.sv
package cmq_pkg;

  localparam int REG_W = 32;

  // register word indexes
  localparam logic [2:0] REG_OP    = 3'd0;
  localparam logic [2:0] REG_ADDR  = 3'd1;
  localparam logic [2:0] REG_SIZE  = 3'd2;
  localparam logic [2:0] REG_WAYS  = 3'd3;
  localparam logic [2:0] REG_ENTRY = 3'd4;
  localparam logic [2:0] REG_QSTAT = 3'd5;
  localparam logic [2:0] REG_PRIM  = 3'd6;

  // operation word fields
  localparam int OP_CMD_LSB   = 0;
  localparam int OP_NOTIFY    = 15;
  localparam int OP_SCOPE_LSB = 17;
  localparam int OP_TGT_LSB   = 21;

  localparam logic [1:0] SCOPE_RANGE = 2'd0;
  localparam logic [1:0] SCOPE_WAYS  = 2'd2;
  localparam logic [1:0] TGT_WAY     = 2'd2;

  localparam logic [REG_W-1:0] PRIM_SYNC = 32'h8;
  localparam int QS_DONE_BIT = 2;

  typedef struct packed {
    logic rdEn;
    logic ldOp;
    logic ldAddr;
    logic ldSize;
    logic ldWays;
    logic clrEntry;
    logic setOvf;
    logic setFail;
    logic startRun;
    logic step;
    logic finish;
    logic clrDone;
  } cmqStb_t;

endpackage

// File: rtl/cmq_dpath.sv
module cmq_dpath
  import cmq_pkg::*;
#(
  parameter int NUM_WAYS   = 8,
  parameter int NUM_SETS   = 64,
  parameter int LINE_BYTES = 128,
  parameter logic [REG_W-1:0] MAX_BYTES = 32'h003F_FF80
) (
  input  logic                clk,
  input  logic                rstN,
  input  cmqStb_t             stb,
  input  logic                busy,
  input  logic [2:0]          rdAddr,
  input  logic [REG_W-1:0]    wrData,
  output logic                fieldsOk,
  output logic                lastLine,
  output logic [REG_W-1:0]    rdData,
  output logic [REG_W-1:0]    lineAddr,
  output logic [2:0]          lineCmd,
  output logic [NUM_WAYS-1:0] lineWays
);

  localparam int LINE_SH = $clog2(LINE_BYTES);
  localparam int CNT_W   = REG_W - LINE_SH + 1;

  logic [REG_W-1:0]    opQ, addrQ, sizeQ;
  logic [NUM_WAYS-1:0] waysQ;
  logic [REG_W-1:0]    curQ;
  logic [CNT_W-1:0]    remainQ;
  logic ovfQ, failQ, errQ, doneQ;

  logic [1:0] scope, tgt;
  logic       isRange, needWays, notify;
  logic [REG_W:0]   spanBytes;
  logic [CNT_W-1:0] rangeLines;
  logic [REG_W-1:0] alignedStart;

  assign scope    = opQ[OP_SCOPE_LSB +: 2];
  assign tgt      = opQ[OP_TGT_LSB +: 2];
  assign notify   = opQ[OP_NOTIFY];
  assign isRange  = (scope == SCOPE_RANGE);
  assign needWays = (scope == SCOPE_WAYS) || (tgt == TGT_WAY);

  assign fieldsOk = (scope != 2'd3) && (tgt != 2'd3)
                  && (!isRange || ((sizeQ != '0) && (sizeQ <= MAX_BYTES)))
                  && (!needWays || (waysQ != '0));

  assign spanBytes  = (REG_W+1)'(addrQ[LINE_SH-1:0]) + (REG_W+1)'(sizeQ)
                    + (REG_W+1)'(LINE_BYTES - 1);
  assign rangeLines = spanBytes[REG_W:LINE_SH];
  assign alignedStart = {addrQ[REG_W-1:LINE_SH], {LINE_SH{1'b0}}};

  // operand registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ   <= '0;
      addrQ <= '0;
      sizeQ <= '0;
      waysQ <= '0;
    end else begin
      if (stb.ldOp)   opQ   <= wrData;
      if (stb.ldAddr) addrQ <= wrData;
      if (stb.ldSize) sizeQ <= wrData;
      if (stb.ldWays) waysQ <= wrData[NUM_WAYS-1:0];
    end
  end

  // line walk counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curQ    <= '0;
      remainQ <= '0;
    end else if (stb.startRun) begin
      curQ    <= isRange ? alignedStart : '0;
      remainQ <= isRange ? rangeLines : CNT_W'(NUM_SETS);
    end else if (stb.step) begin
      curQ    <= curQ + REG_W'(LINE_BYTES);
      remainQ <= remainQ - 1'b1;
    end
  end

  assign lastLine = (remainQ == CNT_W'(1));
  assign lineAddr = curQ;
  assign lineCmd  = opQ[OP_CMD_LSB +: 3];
  assign lineWays = needWays ? waysQ : '1;

  // status flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfQ  <= 1'b0;
      failQ <= 1'b0;
      errQ  <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      if (stb.clrEntry) begin
        ovfQ  <= 1'b0;
        failQ <= 1'b0;
        errQ  <= 1'b0;
      end
      if (stb.setOvf) ovfQ <= 1'b1;
      if (stb.setFail) begin
        failQ <= 1'b1;
        errQ  <= 1'b1;
      end
      if (stb.clrDone) doneQ <= 1'b0;
      if (stb.finish && notify) doneQ <= 1'b1;
    end
  end

  // read data
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (stb.rdEn) begin
      case (rdAddr)
        REG_OP:    rdData <= opQ;
        REG_ADDR:  rdData <= addrQ;
        REG_SIZE:  rdData <= sizeQ;
        REG_WAYS:  rdData <= REG_W'(waysQ);
        REG_ENTRY: rdData <= stb.setFail ? REG_W'(2'b10) : REG_W'({failQ, ovfQ});
        REG_QSTAT: rdData <= REG_W'({doneQ, errQ, busy});
        default:   rdData <= '0;
      endcase
    end
  end

  // R5: a step is only issued while lines remain
  p_step_has_work_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |-> (remainQ != '0));

  // R5: consecutive strobes walk by one line
  p_addr_walk_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && $past(stb.step)) |-> (lineAddr == $past(lineAddr) + REG_W'(LINE_BYTES)));

  // R8: finishing a notifying walk raises done
  p_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.finish && notify) |=> doneQ);

endmodule

// File: rtl/cmq_ctrl.sv
module cmq_ctrl
  import cmq_pkg::*;
#(
  parameter int DRAIN_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busReq,
  input  logic             busWr,
  input  logic [2:0]       busAddr,
  input  logic [REG_W-1:0] busWdata,
  input  logic             fieldsOk,
  input  logic             lastLine,
  output logic             busAck,
  output logic             busy,
  output cmqStb_t          stb
);

  localparam int DW = $clog2(DRAIN_CYCLES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_OPEN, ST_RUN} cmqState_e;

  cmqState_e state, stateNxt;
  logic          syncPend;
  logic [DW-1:0] drainCnt;
  logic accept, wrAcc, rdAcc, running, syncStart, closeRd;

  assign running = (state == ST_RUN);
  assign busy    = (state != ST_IDLE);
  assign accept  = busReq && !busAck
                && !(!busWr && (busAddr == REG_PRIM) && syncPend);
  assign wrAcc   = accept && busWr;
  assign rdAcc   = accept && !busWr;
  assign closeRd = rdAcc && (busAddr == REG_ENTRY) && (state == ST_OPEN);
  assign syncStart = wrAcc && (busAddr == REG_PRIM) && (busWdata == PRIM_SYNC);

  always_comb begin
    stb          = '0;
    stb.rdEn     = rdAcc;
    stb.ldOp     = wrAcc && (busAddr == REG_OP) && !running;
    stb.clrEntry = stb.ldOp;
    stb.setOvf   = wrAcc && (busAddr == REG_OP) && running;
    stb.ldAddr   = wrAcc && (busAddr == REG_ADDR) && !running;
    stb.ldSize   = wrAcc && (busAddr == REG_SIZE) && !running;
    stb.ldWays   = wrAcc && (busAddr == REG_WAYS) && !running;
    stb.startRun = closeRd && fieldsOk;
    stb.setFail  = closeRd && !fieldsOk;
    stb.step     = running;
    stb.finish   = running && lastLine;
    stb.clrDone  = wrAcc && (busAddr == REG_QSTAT) && busWdata[QS_DONE_BIT];
  end

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE: if (stb.ldOp) stateNxt = ST_OPEN;
      ST_OPEN: begin
        if (stb.startRun)     stateNxt = ST_RUN;
        else if (stb.setFail) stateNxt = ST_IDLE;
      end
      ST_RUN:  if (lastLine) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      busAck <= 1'b0;
    end else begin
      state  <= stateNxt;
      busAck <= accept;
    end
  end

  // sync drain: wait for the walk, then count down
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPend <= 1'b0;
      drainCnt <= '0;
    end else if (syncStart) begin
      syncPend <= 1'b1;
      drainCnt <= DW'(DRAIN_CYCLES);
    end else if (syncPend && !running) begin
      if (drainCnt == '0) syncPend <= 1'b0;
      else                drainCnt <= drainCnt - 1'b1;
    end
  end

  // R4: a failed close returns the queue to idle
  p_fail_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.setFail |=> (state == ST_IDLE));

  // R3: an overflowing write does not disturb the running walk
  p_ovf_keeps_run_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setOvf && !lastLine) |=> (state == ST_RUN));

  // R10: a primitive read is held off while a sync drains
  p_sync_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busWr && (busAddr == REG_PRIM) && syncPend) |=> !busAck);

  // R2: the queue only runs after an entry was opened
  p_run_from_open_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> ($past(state) == ST_OPEN));

endmodule

// File: rtl/cmq_top.sv
module cmq_top
  import cmq_pkg::*;
#(
  parameter int NUM_WAYS     = 8,
  parameter int NUM_SETS     = 64,
  parameter int LINE_BYTES   = 128,
  parameter int DRAIN_CYCLES = 8,
  parameter logic [31:0] MAX_BYTES = 32'h003F_FF80
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busReq,
  input  logic                busWr,
  input  logic [2:0]          busAddr,
  input  logic [31:0]         busWdata,
  output logic                busAck,
  output logic [31:0]         busRdata,
  output logic                lineStb,
  output logic [31:0]         lineAddr,
  output logic [2:0]          lineCmd,
  output logic [NUM_WAYS-1:0] lineWays
);

  cmqStb_t stb;
  logic fieldsOk, lastLine, busy;

  cmq_ctrl #(.DRAIN_CYCLES(DRAIN_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .busReq(busReq), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .fieldsOk(fieldsOk), .lastLine(lastLine),
    .busAck(busAck), .busy(busy), .stb(stb)
  );

  cmq_dpath #(
    .NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS),
    .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy),
    .rdAddr(busAddr), .wrData(busWdata),
    .fieldsOk(fieldsOk), .lastLine(lastLine), .rdData(busRdata),
    .lineAddr(lineAddr), .lineCmd(lineCmd), .lineWays(lineWays)
  );

  assign lineStb = stb.step;

endmodule

// File: tb/cmq_top_tb_top.sv
module cmq_top_tb_top;

  localparam int DRAIN = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReq = 1'b0, busWr = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busAck;
  logic [31:0] busRdata;
  logic        lineStb;
  logic [31:0] lineAddr;
  logic [2:0]  lineCmd;
  logic [7:0]  lineWays;

  int checks = 0, bad = 0, cyc = 0;
  int stbCnt = 0, lastStbCyc = 0, ackCyc = 0;
  logic [31:0] firstAddr, lastAddr;
  logic [2:0]  seenCmd;
  logic [7:0]  seenWays;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cmq_top dut_i (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busAck(busAck), .busRdata(busRdata), .lineStb(lineStb),
    .lineAddr(lineAddr), .lineCmd(lineCmd), .lineWays(lineWays)
  );

  always @(negedge clk) begin
    if (lineStb) begin
      if (stbCnt == 0) firstAddr = lineAddr;
      lastAddr = lineAddr;
      seenCmd = lineCmd;
      seenWays = lineWays;
      lastStbCyc = cyc;
      stbCnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [2:0] a, input logic [31:0] d,
                      output logic [31:0] rd);
    @(negedge clk);
    busReq = 1'b1; busWr = wr; busAddr = a; busWdata = d;
    do @(negedge clk); while (!busAck);
    rd = busRdata;
    ackCyc = cyc;
    busReq = 1'b0; busWr = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    logic [31:0] junk;
    xfer(1'b1, a, d, junk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    xfer(1'b0, a, 32'h0, v);
  endtask

  function automatic logic [31:0] opw(input int cmd, input int scope, input int tgt, input bit ce);
    return 32'(cmd) | (32'(scope) << 17) | (32'(tgt) << 21) | (ce ? 32'h8000 : 32'h0);
  endfunction

  task automatic waitIdle(output logic [31:0] qs);
    int n = 0;
    do begin rd(3'd5, qs); n++; end while (qs[0] && n < 500);
  endtask

  task automatic clearDone;
    wr(3'd5, 32'h4);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd4, v); chk("R1 entry status", v, 0);
    rd(3'd5, v); chk("R1 queue status", v, 0);
    chk("R1 no strobes", 32'(stbCnt), 0);
  endtask

  task automatic t_range(input logic [31:0] a, input logic [31:0] sz, input int cmd,
                         input int expLines);
    logic [31:0] v;
    stbCnt = 0;
    wr(3'd0, opw(cmd, 0, 0, 1));
    rd(3'd5, v); chk("R2 busy while open", {31'b0, v[0]}, 1);
    wr(3'd1, a); wr(3'd2, sz);
    rd(3'd4, v); chk("R2 entry accepted", v, 0);
    waitIdle(v);
    chk("R8 status exactly done", v, 4);
    chk("R5 line count", 32'(stbCnt), 32'(expLines));
    chk("R5 first line", firstAddr, a & ~32'h7F);
    chk("R5 last line", lastAddr, (a & ~32'h7F) + 32'(128 * (expLines - 1)));
    chk("R5 command", 32'(seenCmd), 32'(cmd));
    chk("R7 ways all ones", 32'(seenWays), 32'hFF);
    clearDone();
  endtask

  task automatic t_all;
    logic [31:0] v;
    stbCnt = 0;
    wr(3'd0, opw(0, 1, 0, 1)); wr(3'd2, 0);
    rd(3'd4, v); chk("R6 size ignored", v, 0);
    waitIdle(v);
    chk("R6 set count", 32'(stbCnt), 64);
    chk("R6 first set", firstAddr, 0);
    chk("R6 last set", lastAddr, 32'h1F80);
    clearDone();
  endtask

  task automatic t_ways;
    logic [31:0] v;
    stbCnt = 0;
    wr(3'd0, opw(0, 2, 0, 1)); wr(3'd3, 32'h05);
    rd(3'd4, v); waitIdle(v);
    chk("R7 way scope count", 32'(stbCnt), 64);
    chk("R7 way scope mask", 32'(seenWays), 32'h05);
    clearDone();
    stbCnt = 0;
    wr(3'd0, opw(3, 0, 2, 1)); wr(3'd1, 32'h3000_0000); wr(3'd2, 32'h200);
    wr(3'd3, 32'h30);
    rd(3'd4, v); waitIdle(v);
    chk("R7 way target count", 32'(stbCnt), 4);
    chk("R7 way target mask", 32'(seenWays), 32'h30);
    chk("R7 prefetch command", 32'(seenCmd), 3);
    clearDone();
  endtask

  task automatic failCase(input string tag, input logic [31:0] op, input logic [31:0] sz,
                          input logic [31:0] ways);
    logic [31:0] v;
    stbCnt = 0;
    wr(3'd0, op); wr(3'd1, 32'h100); wr(3'd2, sz); wr(3'd3, ways);
    rd(3'd4, v); chk(tag, v, 2);
    repeat (3) @(negedge clk);
    rd(3'd5, v); chk("R4 queue status error, idle", v, 2);
    chk("R4 no strobes", 32'(stbCnt), 0);
  endtask

  task automatic t_fail;
    logic [31:0] v;
    failCase("R4 scope 3", opw(0, 3, 0, 1), 32'h80, 32'h1);
    failCase("R4 target 3", opw(0, 1, 3, 1), 32'h80, 32'h1);
    failCase("R4 zero size", opw(2, 0, 0, 1), 32'h0, 32'h1);
    failCase("R4 size too big", opw(2, 0, 0, 1), 32'h0040_0000, 32'h1);
    failCase("R4 zero ways", opw(0, 2, 0, 1), 32'h80, 32'h0);
    // R11 retry of a good entry
    stbCnt = 0;
    wr(3'd0, opw(1, 0, 0, 1));
    rd(3'd4, v); chk("R11 flags cleared on retry", v, 0);
    waitIdle(v);
    chk("R11 retried entry runs", v, 4);
    chk("R11 retry strobes", 32'(stbCnt), 1);
    clearDone();
  endtask

  task automatic t_ovf;
    logic [31:0] v;
    stbCnt = 0;
    wr(3'd0, opw(2, 1, 0, 1));
    rd(3'd4, v);
    wr(3'd0, opw(5, 0, 0, 1));
    rd(3'd4, v); chk("R3 overflow flag", v, 1);
    waitIdle(v);
    chk("R3 walk unchanged count", 32'(stbCnt), 64);
    chk("R3 walk unchanged command", 32'(seenCmd), 2);
    clearDone();
  endtask

  task automatic t_notify_clear;
    logic [31:0] v;
    wr(3'd0, opw(0, 1, 0, 0));
    rd(3'd4, v); waitIdle(v);
    chk("R8 no notify no done", v, 0);
    wr(3'd0, opw(0, 1, 0, 1));
    rd(3'd4, v); waitIdle(v);
    wr(3'd5, 32'h3);
    rd(3'd5, v); chk("R9 write without bit2 keeps done", v, 4);
    wr(3'd5, 32'h4);
    rd(3'd5, v); chk("R9 write bit2 clears done", v, 0);
  endtask

  task automatic t_sync;
    logic [31:0] v;
    int st;
    stbCnt = 0;
    wr(3'd0, opw(2, 1, 0, 1));
    rd(3'd4, v);
    wr(3'd6, 32'h8);
    rd(3'd6, v);
    chk("R10 walk ended before read ack", 32'(stbCnt), 64);
    chk("R10 drain interval respected", 32'((ackCyc - lastStbCyc) >= DRAIN), 1);
    clearDone();
    wr(3'd6, 32'h9);
    st = cyc;
    rd(3'd6, v);
    chk("R10 other value ignored", 32'((ackCyc - st) <= 2), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_range(32'h1000_0040, 32'h100, 2, 3);
    t_range(32'h2000_0000, 32'h80, 1, 1);
    t_all();
    t_ways();
    t_fail();
    t_ovf();
    t_notify_clear();
    t_sync();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule